// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block turns up to 32 general-purpose input pins into interrupt requests. Each pin passes through a two-flop synchronizer. A per-pin state machine then watches it according to a 4-bit sense mode. The low three bits of the mode pick rising edge, falling edge, both edges, high level or low level. Bit 3 is stored and read back as an asynchronous-detect flag and does not change detection. Every pin has an enable bit, an acceptance bit and a pending flag. The acceptance bit decides whether the pin's detector runs at all. The enable bit decides whether a pending flag reaches a request line.

Software changes enables with separate set and clear registers, and clears latched edges with a write-one-to-clear register. A masked-status register returns the pins that are both pending and enabled. The request lines are `irq_lo` for the lower half of the pins and `irq_hi` for the upper half. Both are serviced by reading that same masked-status register. To change a pin's mode safely, software drops its acceptance bit, rewrites the mode, clears the pending flag and then accepts the pin again.

Each pin cell is a four-state machine:
- `CS_OFF`: the pin is not accepted.
- `CS_WATCH`: the pin is accepted and nothing is pending.
- `CS_EDGE`: an edge has been latched.
- `CS_LEVEL`: the qualifying level is present.

Its transitions are:
- Any state goes to `CS_OFF` when acceptance is low.
- `CS_OFF` and `CS_WATCH` go to `CS_EDGE` on a qualifying edge, to `CS_LEVEL` on a qualifying level, and otherwise to `CS_WATCH`.
- `CS_EDGE` stays put until cleared, then returns to `CS_WATCH`. A new edge in the same cycle as the clear keeps it in `CS_EDGE`.
- `CS_LEVEL` falls back to `CS_WATCH` when the level goes away or a clear is written. If the level is still present, it re-enters `CS_LEVEL` on the next cycle.

Top module: `sense_irq_ctrl`

## Requirements
- R1: After reset, every enable, acceptance, pending and mode bit reads 0, and both request lines are low.
- R2: Pin n's mode sits in the mode register at byte address 0x20 + 4*(n/8), bits 4*(n%8)+3 down to 4*(n%8). All 4 bits are stored and read back, and bit 3 does not alter detection.
- R3: Writing 1s at 0x00 sets enable bits and writing 1s at 0x04 clears them. Bits written as 0 are left unchanged, and both addresses read back the enable vector.
- R4: A pin whose acceptance bit (register 0x08, read/write) is 0 never raises its pending flag. Clearing the acceptance bit discards a pending flag the pin already holds.
- R5: Mode code 0 latches on a rising edge, 1 on a falling edge and 4 on either edge. The flag is visible at 0x0C within five cycles of the pin change. It holds until a 1 is written to the pin's bit at 0x0C.
- R6: In mode 2 (high level) and mode 3 (low level) the pending flag follows the synchronized pin level. A clear written at 0x0C has no lasting effect while the level persists.
- R7: Mode codes 5, 6 and 7 never raise a pending flag.
- R8: Address 0x0C reads the raw pending vector. Address 0x10 reads pending AND enable.
- R9: `irq_lo` is high exactly when masked status bits 15..0 are nonzero, and `irq_hi` is high exactly when bits 31..16 are nonzero.
- R10: Accepting a pin again while its input already sits past an edge does not create a pending flag. Edge history keeps running while the pin is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read byte address (combinational read) |
| rd_data | output | 32 | Read data |
| irq_lo | output | 1 | Request for pins 0..15 |
| irq_hi | output | 1 | Request for pins 16..31 |

## Verification
The bench targets several faults, each with a visible symptom:
- A latched edge is lost once the pin returns to rest; a design that fails to latch would read 0 after the pin falls again.
- A level-mode clear is written while the level is held; a design that latches levels like edges would stay cleared.
- A pin is accepted again while already high in rising mode; a design that holds its edge history in reset while the pin is not accepted would report a false edge.
- The set and clear enable writes are checked against untouched neighbouring bits.
- A pin in the upper half is checked against the correct request line; a swapped or merged mapping would light the wrong request.

// File: rtl/sense_pkg.sv
package sense_pkg;

    localparam int unsigned FIELD_W   = 4;
    localparam int unsigned CODE_W    = 3;
    localparam int unsigned PER_REG   = 8;
    localparam int unsigned ADDR_W    = 6;
    localparam int unsigned DW        = 32;

    localparam logic [ADDR_W-1:0] A_EN_SET = 6'h00;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 6'h04;
    localparam logic [ADDR_W-1:0] A_ACCEPT = 6'h08;
    localparam logic [ADDR_W-1:0] A_PEND   = 6'h0C;
    localparam logic [ADDR_W-1:0] A_MSTAT  = 6'h10;
    localparam logic [ADDR_W-1:0] A_MODE0  = 6'h20;

    localparam logic [CODE_W-1:0] MD_RISE = 3'd0;
    localparam logic [CODE_W-1:0] MD_FALL = 3'd1;
    localparam logic [CODE_W-1:0] MD_HIGH = 3'd2;
    localparam logic [CODE_W-1:0] MD_LOW  = 3'd3;
    localparam logic [CODE_W-1:0] MD_BOTH = 3'd4;

    typedef enum logic [1:0] {
        CS_OFF   = 2'd0,
        CS_WATCH = 2'd1,
        CS_EDGE  = 2'd2,
        CS_LEVEL = 2'd3
    } cell_state_e;

    function automatic logic [ADDR_W-1:0] mode_addr(input int unsigned k);
        return ADDR_W'(32'(A_MODE0) + 4 * k);
    endfunction

endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);

    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= din;
            cur_q  <= meta_q;
            prv_q  <= cur_q;
        end
    end

    assign cur = cur_q;
    assign prv = prv_q;

endmodule

// File: rtl/sense_cell.sv
module sense_cell
    import sense_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [CODE_W-1:0] code,
    input  logic              cur,
    input  logic              prv,
    input  logic              clr,
    output logic              pend
);

    cell_state_e state_q;
    cell_state_e state_d;

    logic rise;
    logic fall;
    logic edge_mode;
    logic edge_hit;
    logic level_on;

    always_comb begin
        rise      = cur & ~prv;
        fall      = ~cur & prv;
        edge_mode = (code == MD_RISE) || (code == MD_FALL) || (code == MD_BOTH);
        edge_hit  = ((code == MD_RISE) && rise) ||
                    ((code == MD_FALL) && fall) ||
                    ((code == MD_BOTH) && (rise || fall));
        level_on  = ((code == MD_HIGH) && cur) ||
                    ((code == MD_LOW)  && !cur);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_OFF, CS_WATCH: begin
                if (edge_hit)
                    state_d = CS_EDGE;
                else if (level_on && !clr)
                    state_d = CS_LEVEL;
                else
                    state_d = CS_WATCH;
            end
            CS_EDGE: begin
                if (edge_hit)
                    state_d = CS_EDGE;
                else if (edge_mode && !clr)
                    state_d = CS_EDGE;
                else if (level_on && !clr)
                    state_d = CS_LEVEL;
                else
                    state_d = CS_WATCH;
            end
            CS_LEVEL: begin
                if (edge_hit)
                    state_d = CS_EDGE;
                else if (level_on && !clr)
                    state_d = CS_LEVEL;
                else
                    state_d = CS_WATCH;
            end
            default: state_d = CS_OFF;
        endcase
        if (!accept)
            state_d = CS_OFF;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CS_OFF;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CS_EDGE, CS_LEVEL: pend = 1'b1;
            default:           pend = 1'b0;
        endcase
    end

endmodule

// File: rtl/sense_regs.sv
module sense_regs
    import sense_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DW-1:0]             wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DW-1:0]             rd_data,
    input  logic [NPINS-1:0]          pend_i,
    output logic [NPINS-1:0]          enable_o,
    output logic [NPINS-1:0]          accept_o,
    output logic [NPINS*CODE_W-1:0]   codes_o,
    output logic [NPINS-1:0]          clr_o
);

    localparam int unsigned NMODE = (NPINS + PER_REG - 1) / PER_REG;

    logic [NPINS-1:0] enable_q;
    logic [NPINS-1:0] accept_q;
    logic [DW-1:0]    mode_q [NMODE];
    logic [NPINS-1:0] wbits;

    assign wbits = wr_data[NPINS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            accept_q <= '0;
            for (int k = 0; k < NMODE; k++)
                mode_q[k] <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_EN_SET)
                enable_q <= enable_q | wbits;
            if (wr_addr == A_EN_CLR)
                enable_q <= enable_q & ~wbits;
            if (wr_addr == A_ACCEPT)
                accept_q <= wbits;
            for (int k = 0; k < NMODE; k++)
                if (wr_addr == mode_addr(k))
                    mode_q[k] <= wr_data;
        end
    end

    assign clr_o = (wr_en && (wr_addr == A_PEND)) ? wbits : '0;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_EN_SET, A_EN_CLR: rd_data = DW'(enable_q);
            A_ACCEPT:           rd_data = DW'(accept_q);
            A_PEND:             rd_data = DW'(pend_i);
            A_MSTAT:            rd_data = DW'(pend_i & enable_q);
            default:            rd_data = '0;
        endcase
        for (int k = 0; k < NMODE; k++)
            if (rd_addr == mode_addr(k))
                rd_data = mode_q[k];
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_code
        assign codes_o[i*CODE_W +: CODE_W] =
            mode_q[i / PER_REG][(i % PER_REG) * FIELD_W +: CODE_W];
    end

    assign enable_o = enable_q;
    assign accept_o = accept_q;

endmodule

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl
    import sense_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq_lo,
    output logic              irq_hi
);

    localparam int unsigned HALF = NPINS / 2;

    logic [NPINS-1:0]        cur_w;
    logic [NPINS-1:0]        prv_w;
    logic [NPINS-1:0]        pend_w;
    logic [NPINS-1:0]        enable_w;
    logic [NPINS-1:0]        accept_w;
    logic [NPINS-1:0]        clr_w;
    logic [NPINS*CODE_W-1:0] codes_w;
    logic [NPINS-1:0]        live_w;

    sense_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i),
        .cur   (cur_w),
        .prv   (prv_w)
    );

    sense_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pend_i   (pend_w),
        .enable_o (enable_w),
        .accept_o (accept_w),
        .codes_o  (codes_w),
        .clr_o    (clr_w)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_cell
        sense_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .accept (accept_w[i]),
            .code   (codes_w[i*CODE_W +: CODE_W]),
            .cur    (cur_w[i]),
            .prv    (prv_w[i]),
            .clr    (clr_w[i]),
            .pend   (pend_w[i])
        );
    end

    assign live_w = pend_w & enable_w;
    assign irq_lo = |live_w[HALF-1:0];
    assign irq_hi = |live_w[NPINS-1:HALF];

endmodule

// File: rtl/sense_irq_ctrl_chk.sv
module sense_irq_ctrl_chk
    import sense_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_lo,
    input logic                      irq_hi,
    input logic                      wr_en,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic [DW-1:0]             wr_data,
    input logic [ADDR_W-1:0]         rd_addr,
    input logic [DW-1:0]             rd_data,
    input logic [NPINS-1:0]          pend,
    input logic [NPINS-1:0]          enable_q,
    input logic [NPINS-1:0]          accept_q,
    input logic [NPINS*CODE_W-1:0]   codes
);

    localparam int unsigned HALF = NPINS / 2;

    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_SET) |=>
        ((enable_q & $past(wr_data[NPINS-1:0])) == $past(wr_data[NPINS-1:0]))); // R3

    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_CLR) |=>
        ((enable_q & $past(wr_data[NPINS-1:0])) == '0)); // R3

    AST_NO_PEND_UNACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(accept_q)) == '0)); // R4

    AST_IRQ_LO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MSTAT) |-> (irq_lo == (|rd_data[HALF-1:0]))); // R9

    AST_IRQ_HI_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == A_MSTAT) |-> (irq_hi == (|rd_data[NPINS-1:HALF]))); // R9

    for (genvar i = 0; i < NPINS; i++) begin : g_rsv
        AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(codes[i*CODE_W +: CODE_W]) > MD_BOTH) |-> !pend[i]); // R7
    end

endmodule

bind sense_irq_ctrl sense_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pend     (pend_w),
    .enable_q (enable_w),
    .accept_q (accept_w),
    .codes    (codes_w)
);

// File: tb/tb_sense_irq_ctrl.sv
module tb_sense_irq_ctrl;
    import sense_pkg::*;

    localparam logic [5:0] IRQ_VIEW = 6'h3F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pin;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data;
    logic [5:0]  rd_addr;
    logic [31:0] rd_data;
    logic        irq_lo;
    logic        irq_hi;

    always #10 clk = ~clk;

    sense_irq_ctrl dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

    typedef struct {
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    q_n    = 0;
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 0;

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        q_n++;
        wait (q_n == 0);
    endtask

    task automatic set_pin(input int i, input bit v);
        @(negedge clk);
        pin[i] = v;
        repeat (5) @(negedge clk);
    endtask

    // monitor: pops expected items and compares with the design
    initial begin
        item_t       it;
        logic [31:0] got;
        forever begin
            wait (q_n > 0);
            @(negedge clk);
            it = sbq.pop_front();
            rd_addr = (it.addr == IRQ_VIEW) ? A_MSTAT : it.addr;
            #2;
            got = (it.addr == IRQ_VIEW) ? {30'b0, irq_hi, irq_lo} : rd_data;
            n_run++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h got=%h exp=%h", it.tag, it.addr, got, it.exp);
            end
            q_n--;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        expect_rd(A_EN_SET, 32'h0, "R1 enable");
        expect_rd(A_ACCEPT, 32'h0, "R1 accept");
        expect_rd(A_PEND,   32'h0, "R1 pending");
        expect_rd(A_MODE0,  32'h0, "R1 mode");
        expect_rd(IRQ_VIEW, 32'h0, "R1 irq");

        // pin0 rise, pin1 fall, pin2 high, pin3 low, pin4 both, pin5 rsv, pin6 rise w/o bit3
        wr(A_MODE0, 32'h80DC_BA98);
        wr(mode_addr(1), 32'h1234_5678);
        wr(mode_addr(2), 32'h8888_8888);
        expect_rd(A_MODE0, 32'h80DC_BA98, "R2 readback reg0");
        expect_rd(mode_addr(1), 32'h1234_5678, "R2 readback reg1");

        set_pin(0, 1); set_pin(0, 0);
        expect_rd(A_PEND, 32'h0, "R4 not accepted");

        wr(A_ACCEPT, 32'h77);
        repeat (4) @(negedge clk);
        expect_rd(A_PEND, 32'h0, "R5 idle accepted");

        set_pin(0, 1);
        expect_rd(A_PEND, 32'h1, "R5 rising latched");
        expect_rd(A_MSTAT, 32'h0, "R8 masked by enable");
        expect_rd(IRQ_VIEW, 32'h0, "R9 no irq when disabled");
        set_pin(0, 0);
        expect_rd(A_PEND, 32'h1, "R5 holds after pin falls");

        wr(A_EN_SET, 32'h1);
        expect_rd(A_MSTAT, 32'h1, "R8 masked status");
        expect_rd(IRQ_VIEW, 32'h1, "R9 low line");
        wr(A_PEND, 32'h1);
        expect_rd(A_PEND, 32'h0, "R5 clear");
        expect_rd(IRQ_VIEW, 32'h0, "R9 low line drops");

        set_pin(1, 1);
        expect_rd(A_PEND, 32'h0, "R5 falling ignores rise");
        set_pin(1, 0);
        expect_rd(A_PEND, 32'h2, "R5 falling latched");
        wr(A_PEND, 32'h2);

        set_pin(4, 1);
        expect_rd(A_PEND, 32'h10, "R5 both on rise");
        wr(A_PEND, 32'h10);
        set_pin(4, 0);
        expect_rd(A_PEND, 32'h10, "R5 both on fall");
        wr(A_PEND, 32'h10);
        expect_rd(A_PEND, 32'h0, "R5 both cleared");

        set_pin(6, 1);
        expect_rd(A_PEND, 32'h40, "R2 bit3 clear still detects");
        wr(A_PEND, 32'h40);
        set_pin(6, 0);

        set_pin(5, 1);
        expect_rd(A_PEND, 32'h0, "R7 reserved rise");
        set_pin(5, 0);
        expect_rd(A_PEND, 32'h0, "R7 reserved fall");

        set_pin(2, 1);
        expect_rd(A_PEND, 32'h4, "R6 high level");
        wr(A_PEND, 32'h4);
        repeat (3) @(negedge clk);
        expect_rd(A_PEND, 32'h4, "R6 clear no lasting effect");
        set_pin(2, 0);
        expect_rd(A_PEND, 32'h0, "R6 level gone");

        wr(A_ACCEPT, 32'h7F);
        repeat (4) @(negedge clk);
        expect_rd(A_PEND, 32'h8, "R6 low level");
        set_pin(3, 1);
        expect_rd(A_PEND, 32'h0, "R6 low level gone");

        set_pin(0, 1);
        expect_rd(A_PEND, 32'h1, "R4 setup edge");
        wr(A_ACCEPT, 32'h7E);
        repeat (2) @(negedge clk);
        expect_rd(A_PEND, 32'h0, "R4 accept drop discards");
        wr(A_ACCEPT, 32'h7F);
        repeat (4) @(negedge clk);
        expect_rd(A_PEND, 32'h0, "R10 no spurious edge");

        wr(A_EN_SET, 32'h0F00_0000);
        wr(A_EN_CLR, 32'h0100_0001);
        expect_rd(A_EN_SET, 32'h0E00_0000, "R3 set/clear");
        expect_rd(A_EN_CLR, 32'h0E00_0000, "R3 readback at clear addr");

        wr(A_ACCEPT, 32'h0001_007F);
        wr(A_EN_SET, 32'h0001_0000);
        set_pin(16, 1);
        expect_rd(A_MSTAT, 32'h0001_0000, "R8 upper pin");
        expect_rd(IRQ_VIEW, 32'h2, "R9 high line");
        wr(A_EN_CLR, 32'h0001_0000);
        expect_rd(A_MSTAT, 32'h0, "R8 disabled");
        expect_rd(IRQ_VIEW, 32'h0, "R9 high line drops");
        expect_rd(A_PEND, 32'h0001_0000, "R8 raw keeps pending");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule